// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block decides, within the same cycle, whether a physical memory access may go ahead. It holds a parameterized number of protection entries. Each entry has an 8-bit configuration byte and an address register that stores the physical address shifted right by the granule shift. A request has three parts: the physical address, the kind of access (instruction fetch, data load or data store) and the privilege level of the requester (user, supervisor or machine). The block returns an allow flag and a fault-cause code. The code is zero when the access is allowed. When the access is denied, it names an instruction, load or store access fault.

An entry describes a region in one of three ways. A top-of-range entry covers the span that starts at the previous entry's address and ends just below its own. A four-byte entry covers exactly one word. A power-of-two entry covers an aligned block whose size is encoded in the trailing ones of its address register. Entries are searched from the lowest index upward, and the first enabled entry that contains the address decides the result. Machine-level requests pass an entry unless that entry is locked. Machine-level requests are also the only ones allowed when no entry matches. Two simple synchronous write ports load the configuration bytes and the address registers.

Top module: `pmpc_checker`

## Requirements
- R1: After reset every configuration byte and every address register is zero, so no entry is enabled.
- R2: Configuration byte layout: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 region kind (0 disabled, 1 top-of-range, 2 four-byte, 3 power-of-two), bit 7 lock. A write strobe with an in-range select updates the selected register at the next rising clock edge, and the old contents govern the result until that edge.
- R3: A write whose select is NUM_ENTRIES or larger changes no register.
- R4: A top-of-range entry i contains address A when L <= A < (adr[i] << GRAN_SHIFT). L is zero for entry 0 and (adr[i-1] << GRAN_SHIFT) otherwise, even when entry i-1 is disabled.
- R5: A four-byte entry contains exactly the bytes from (adr << GRAN_SHIFT) through that address plus 3.
- R6: A power-of-two entry whose address register ends in k one bits, with the next bit above them zero, contains the block of 2^(k+3) bytes that holds (adr << GRAN_SHIFT) and is aligned to its own size. An entry whose register is all ones contains every address.
- R7: Only the lowest-indexed enabled entry that contains the address affects the result.
- R8: Access kind encoding is 0 fetch, 1 load, 2 store. Privilege encoding is 0 user, 1 supervisor, 3 machine. On a match, a machine request to an unlocked entry is allowed. Any other request is allowed only when the execute bit is set for a fetch, the read bit for a load, or the write bit for a store.
- R9: A locked matching entry applies its permission bits to machine requests as well.
- R10: When no enabled entry contains the address, only machine requests are allowed.
- R11: The cause output is 0 when the access is allowed. When it is denied, the cause is 1 for a fetch, 5 for a load and 7 for a store.
- R12: The allow flag and the cause depend combinationally on the request and the current register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register write ports |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_sel | input | IDX_W (3) | Entry index for the configuration write |
| cfg_wdata | input | 8 | Configuration byte to write |
| adr_we | input | 1 | Address register write strobe |
| adr_sel | input | IDX_W (3) | Entry index for the address write |
| adr_wdata | input | PA_WIDTH-GRAN_SHIFT (30) | Address register value (physical address >> GRAN_SHIFT) |
| chk_addr | input | PA_WIDTH (32) | Physical byte address of the request |
| chk_type | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| chk_priv | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| chk_allow | output | 1 | High when the request may proceed |
| chk_cause | output | 4 | 0 allowed, 1 fetch fault, 5 load fault, 7 store fault |

## Verification
The bench builds the block with NUM_ENTRIES = 6, PA_WIDTH = 32 and GRAN_SHIFT = 2. Because six is not a power of two, the 3-bit selects 6 and 7 exist but name no entry, which puts the ignored-write case within reach. A 32-bit address with a 30-bit register lets an all-ones power-of-two entry span the whole space, which exercises the top end of the mask arithmetic. Random programming packs all regions into the first kilobyte so that overlaps and first-match priority come up often.

// File: rtl/pmpc_pkg.sv
package pmpc_pkg;

   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_LOAD  = 2'd1,
      ACC_STORE = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_e;

   typedef enum logic [1:0] {
      PRV_USER  = 2'd0,
      PRV_SUPER = 2'd1,
      PRV_RSVD  = 2'd2,
      PRV_MACH  = 2'd3
   } prv_e;

   typedef enum logic [1:0] {
      AM_OFF   = 2'd0,
      AM_TOR   = 2'd1,
      AM_NA4   = 2'd2,
      AM_NAPOT = 2'd3
   } amode_e;

   typedef struct packed {
      logic       lock;
      logic [1:0] spare;
      amode_e     mode;
      logic       x;
      logic       w;
      logic       r;
   } ecfg_t;

   localparam logic [3:0] CAUSE_NONE   = 4'd0;
   localparam logic [3:0] CAUSE_IFAULT = 4'd1;
   localparam logic [3:0] CAUSE_LFAULT = 4'd5;
   localparam logic [3:0] CAUSE_SFAULT = 4'd7;

   function automatic logic [3:0] fault_code(input acc_e kind);
      case (kind)
         ACC_FETCH: fault_code = CAUSE_IFAULT;
         ACC_LOAD:  fault_code = CAUSE_LFAULT;
         default:   fault_code = CAUSE_SFAULT;
      endcase
   endfunction

endpackage

// File: rtl/pmpc_cfg_store.sv
module pmpc_cfg_store #(
   parameter int NUM_ENTRIES = 8,
   parameter int AR_W        = 30,
   parameter int IDX_W       = 3
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  cfg_we,
   input  logic [IDX_W-1:0]                      cfg_sel,
   input  logic [7:0]                            cfg_wdata,
   input  logic                                  adr_we,
   input  logic [IDX_W-1:0]                      adr_sel,
   input  logic [AR_W-1:0]                       adr_wdata,
   output logic [NUM_ENTRIES-1:0][7:0]           cfg_q,
   output logic [NUM_ENTRIES-1:0][AR_W-1:0]      adr_q
);

   localparam logic [IDX_W:0] N_LIM = (IDX_W+1)'(NUM_ENTRIES);

   logic cfg_ok;
   logic adr_ok;

   assign cfg_ok = ({1'b0, cfg_sel} < N_LIM);
   assign adr_ok = ({1'b0, adr_sel} < N_LIM);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
         adr_q <= '0;
      end else begin
         if (cfg_we && cfg_ok) cfg_q[cfg_sel] <= cfg_wdata;
         if (adr_we && adr_ok) adr_q[adr_sel] <= adr_wdata;
      end
   end

   // R2
   cfg_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_ok) |=> (cfg_q[$past(cfg_sel)] == $past(cfg_wdata)));

   // R2
   adr_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adr_we && adr_ok) |=> (adr_q[$past(adr_sel)] == $past(adr_wdata)));

   // R3
   cfg_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_ok) |=> $stable(cfg_q));

   // R3
   adr_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adr_we && !adr_ok) |=> $stable(adr_q));

endmodule

// File: rtl/pmpc_region_match.sv
module pmpc_region_match
   import pmpc_pkg::*;
#(
   parameter int PA_WIDTH   = 32,
   parameter int GRAN_SHIFT = 2,
   localparam int AR_W      = PA_WIDTH - GRAN_SHIFT
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          mode,
   input  logic [AR_W-1:0]     adr_cur,
   input  logic [AR_W-1:0]     adr_low,
   input  logic [PA_WIDTH-1:0] addr,
   output logic                hit
);

   logic [PA_WIDTH-1:0] upper;
   logic [PA_WIDTH-1:0] lower;
   logic [AR_W:0]       t_val;
   logic [AR_W:0]       t_keep;
   logic [PA_WIDTH-1:0] cmp_mask;
   amode_e              kind;

   assign kind   = amode_e'(mode);
   assign upper  = {adr_cur, {GRAN_SHIFT{1'b0}}};
   assign lower  = {adr_low, {GRAN_SHIFT{1'b0}}};
   // trailing ones of t mark the address bits that are free inside the region
   assign t_val  = {adr_cur, (kind != AM_NA4)};
   assign t_keep = ~(t_val & ~(t_val + {{AR_W{1'b0}}, 1'b1}));
   assign cmp_mask = PA_WIDTH'({t_keep, {GRAN_SHIFT{1'b0}}});

   always_comb begin
      case (kind)
         AM_OFF:  hit = 1'b0;
         AM_TOR:  hit = (addr >= lower) && (addr < upper);
         default: hit = (((addr ^ upper) & cmp_mask) == '0);
      endcase
   end

   // R5
   na4_exact_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == AM_NA4 && hit) |-> (addr[PA_WIDTH-1:GRAN_SHIFT] == adr_cur));

   // R4
   tor_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == AM_TOR && hit) |-> (adr_low < adr_cur));

endmodule

// File: rtl/pmpc_first_match.sv
module pmpc_first_match
   import pmpc_pkg::*;
#(
   parameter int NUM_ENTRIES = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_ENTRIES-1:0]      hit,
   input  logic [NUM_ENTRIES-1:0][7:0] cfg,
   input  logic [1:0]                  acc_type,
   input  logic [1:0]                  priv,
   output logic                        allow
);

   acc_e kind;
   logic is_mach;
   logic [NUM_ENTRIES:0]   seen;
   logic [NUM_ENTRIES-1:0] take;
   logic [NUM_ENTRIES-1:0] perm;

   assign kind    = acc_e'(acc_type);
   assign is_mach = (prv_e'(priv) == PRV_MACH);
   assign seen[0] = 1'b0;

   for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
      ecfg_t c;
      assign c = ecfg_t'(cfg[i]);
      assign perm[i] = (is_mach && !c.lock) ||
                       (kind == ACC_FETCH && c.x) ||
                       (kind == ACC_LOAD  && c.r) ||
                       (kind == ACC_STORE && c.w);
      assign take[i]   = hit[i] && !seen[i];
      assign seen[i+1] = seen[i] | hit[i];
   end

   assign allow = (|(take & perm)) | (!seen[NUM_ENTRIES] && is_mach);

   // R10
   nomatch_mach_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit == '0 && priv == 2'd3) |-> allow);

   // R10
   nomatch_low_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit == '0 && priv != 2'd3) |-> !allow);

   // R8
   mach_unlocked_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[0] && !cfg[0][7] && priv == 2'd3) |-> allow);

   // R9
   locked_binds_mach_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[0] && cfg[0][7] && cfg[0][2:0] == 3'b000) |-> !allow);

endmodule

// File: rtl/pmpc_checker.sv
module pmpc_checker
   import pmpc_pkg::*;
#(
   parameter int NUM_ENTRIES = 8,
   parameter int PA_WIDTH    = 32,
   parameter int GRAN_SHIFT  = 2,
   localparam int AR_W       = PA_WIDTH - GRAN_SHIFT,
   localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [IDX_W-1:0]    cfg_sel,
   input  logic [7:0]          cfg_wdata,
   input  logic                adr_we,
   input  logic [IDX_W-1:0]    adr_sel,
   input  logic [AR_W-1:0]     adr_wdata,
   input  logic [PA_WIDTH-1:0] chk_addr,
   input  logic [1:0]          chk_type,
   input  logic [1:0]          chk_priv,
   output logic                chk_allow,
   output logic [3:0]          chk_cause
);

   if (NUM_ENTRIES < 1 || NUM_ENTRIES > 64) begin : g_bad_count
      $error("pmpc_checker: NUM_ENTRIES must lie in 1..64");
   end
   if (GRAN_SHIFT < 2) begin : g_bad_gran
      $error("pmpc_checker: GRAN_SHIFT must be at least 2");
   end
   if (PA_WIDTH < GRAN_SHIFT + 4 || PA_WIDTH > 62) begin : g_bad_width
      $error("pmpc_checker: PA_WIDTH out of range");
   end

   logic [NUM_ENTRIES-1:0][7:0]      cfg_q;
   logic [NUM_ENTRIES-1:0][AR_W-1:0] adr_q;
   logic [NUM_ENTRIES-1:0][AR_W-1:0] low_adr;
   logic [NUM_ENTRIES-1:0]           hit;

   pmpc_cfg_store #(
      .NUM_ENTRIES (NUM_ENTRIES),
      .AR_W        (AR_W),
      .IDX_W       (IDX_W)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .adr_we    (adr_we),
      .adr_sel   (adr_sel),
      .adr_wdata (adr_wdata),
      .cfg_q     (cfg_q),
      .adr_q     (adr_q)
   );

   for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_region
      if (i == 0) begin : g_first
         assign low_adr[i] = '0;
      end else begin : g_chain
         // bound comes from the neighbour whatever its own kind
         assign low_adr[i] = adr_q[i-1];
      end

      pmpc_region_match #(
         .PA_WIDTH   (PA_WIDTH),
         .GRAN_SHIFT (GRAN_SHIFT)
      ) u_match (
         .clk     (clk),
         .rst_n   (rst_n),
         .mode    (cfg_q[i][4:3]),
         .adr_cur (adr_q[i]),
         .adr_low (low_adr[i]),
         .addr    (chk_addr),
         .hit     (hit[i])
      );
   end

   pmpc_first_match #(
      .NUM_ENTRIES (NUM_ENTRIES)
   ) u_pick (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (hit),
      .cfg      (cfg_q),
      .acc_type (chk_type),
      .priv     (chk_priv),
      .allow    (chk_allow)
   );

   assign chk_cause = chk_allow ? CAUSE_NONE : fault_code(acc_e'(chk_type));

   // R11
   allowed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chk_allow |-> (chk_cause == 4'd0));

   // R11
   denied_coded_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_allow |-> (chk_cause != 4'd0));

endmodule

// File: tb/pmpc_checker_bench.sv
module pmpc_checker_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NE   = 6;
   localparam int PA   = 32;
   localparam int ARW  = 30;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           cfg_we = 1'b0;
   logic [2:0]     cfg_sel = '0;
   logic [7:0]     cfg_wdata = '0;
   logic           adr_we = 1'b0;
   logic [2:0]     adr_sel = '0;
   logic [ARW-1:0] adr_wdata = '0;
   logic [PA-1:0]  chk_addr = '0;
   logic [1:0]     chk_type = '0;
   logic [1:0]     chk_priv = '0;
   logic           chk_allow;
   logic [3:0]     chk_cause;

   int errors = 0;
   int checks = 0;

   logic [7:0]     sh_cfg [NE];
   logic [ARW-1:0] sh_adr [NE];

   always #(CLK_PERIOD/2) clk = ~clk;

   pmpc_checker #(.NUM_ENTRIES(NE), .PA_WIDTH(PA), .GRAN_SHIFT(2)) u_pmpc_checker (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .adr_we(adr_we), .adr_sel(adr_sel), .adr_wdata(adr_wdata),
      .chk_addr(chk_addr), .chk_type(chk_type), .chk_priv(chk_priv),
      .chk_allow(chk_allow), .chk_cause(chk_cause)
   );

   function automatic logic [3:0] exp_code(input int t, input bit ok);
      if (ok) return 4'd0;
      if (t == 0) return 4'd1;
      if (t == 1) return 4'd5;
      return 4'd7;
   endfunction

   // reference decision written from the requirements (region by base and size)
   function automatic bit ref_allow(input logic [31:0] a, input int t, input int p);
      logic [63:0] av, lo, hi, base, size;
      int k;
      bit hit;
      av = {32'b0, a};
      for (int i = 0; i < NE; i++) begin
         hi = {32'b0, sh_adr[i], 2'b00};
         lo = (i == 0) ? 64'd0 : {32'b0, sh_adr[i-1], 2'b00};
         hit = 1'b0;
         case (sh_cfg[i][4:3])
            2'd1: hit = (av >= lo) && (av < hi);
            2'd2: hit = (av >= hi) && (av < hi + 64'd4);
            2'd3: begin
               k = 0;
               while (k < ARW && sh_adr[i][k]) k++;
               size = 64'd1 << (k + 3);
               base = hi & ~(size - 64'd1);
               hit = (av >= base) && (av < base + size);
            end
            default: hit = 1'b0;
         endcase
         if (hit)
            return (p == 3 && !sh_cfg[i][7]) || (t == 0 && sh_cfg[i][2]) ||
                   (t == 1 && sh_cfg[i][0]) || (t == 2 && sh_cfg[i][1]);
      end
      return (p == 3);
   endfunction

   task automatic expect_now(input bit exp, input string tag);
      logic [3:0] ec;
      ec = exp_code(int'(chk_type), exp);
      checks++;
      if (chk_allow !== exp || chk_cause !== ec) begin
         errors++;
         $display("FAIL %s addr=%h type=%0d priv=%0d: allow=%b cause=%0d expected allow=%b cause=%0d",
                  tag, chk_addr, chk_type, chk_priv, chk_allow, chk_cause, exp, ec);
      end
   endtask

   task automatic check(input logic [31:0] a, input int t, input int p, input bit exp,
                        input string tag);
      @(negedge clk);
      chk_addr = a;
      chk_type = t[1:0];
      chk_priv = p[1:0];
      #1;
      expect_now(exp, tag);
   endtask

   task automatic wr_cfg(input int idx, input logic [7:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = idx[2:0]; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
      if (idx < NE) sh_cfg[idx] = v;
   endtask

   task automatic wr_adr(input int idx, input logic [ARW-1:0] v);
      @(negedge clk);
      adr_we = 1'b1; adr_sel = idx[2:0]; adr_wdata = v;
      @(negedge clk);
      adr_we = 1'b0;
      if (idx < NE) sh_adr[idx] = v;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < NE; i++) begin sh_cfg[i] = '0; sh_adr[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 / R10 / R11: nothing enabled after reset
      check(32'h100, 1, 0, 1'b0, "R1 user load after reset");
      check(32'h100, 0, 3, 1'b1, "R10 machine fetch, no match");
      check(32'h100, 2, 1, 1'b0, "R11 supervisor store cause 7");
      check(32'h100, 0, 0, 1'b0, "R11 user fetch cause 1");

      // R4: entry 1 top-of-range, lower bound from a disabled entry 0
      wr_adr(0, 30'h10);
      wr_adr(1, 30'h40);
      wr_cfg(1, 8'h09);
      check(32'h40, 1, 0, 1'b1, "R4 lower bound inclusive");
      check(32'h3C, 1, 0, 1'b0, "R4 below lower bound");
      check(32'hFC, 1, 0, 1'b1, "R4 last byte below top");
      check(32'h100, 1, 0, 1'b0, "R4 top exclusive");
      check(32'h80, 2, 0, 1'b0, "R8 store without write bit");

      // R7 / R6: entry 0 TOR 0..3F execute only, entry 2 NAPOT 0..3FF all
      wr_cfg(0, 8'h0C);
      wr_adr(2, 30'h7F);
      wr_cfg(2, 8'h1F);
      check(32'h0, 0, 0, 1'b1, "R4 entry 0 from zero");
      check(32'h20, 1, 0, 1'b0, "R7 entry 0 decides over entry 2");
      check(32'h44, 0, 0, 1'b0, "R7 entry 1 decides over entry 2");
      check(32'h200, 1, 0, 1'b1, "R6 1KiB region interior");
      check(32'h3FC, 2, 0, 1'b1, "R6 1KiB region top word");
      check(32'h400, 1, 0, 1'b0, "R6 just past region");

      // R5: four-byte entry at 0x500 write only
      wr_adr(3, 30'h140);
      wr_cfg(3, 8'h12);
      check(32'h500, 2, 1, 1'b1, "R5 word start");
      check(32'h503, 2, 1, 1'b1, "R5 word last byte");
      check(32'h504, 2, 1, 1'b0, "R5 next word");
      check(32'h4FC, 2, 1, 1'b0, "R5 previous word");

      // R8 / R9: 8-byte region at 0x600 with no permission bits
      wr_adr(4, 30'h180);
      wr_cfg(4, 8'h18);
      check(32'h604, 1, 3, 1'b1, "R8 machine bypass unlocked");
      check(32'h604, 1, 1, 1'b0, "R8 supervisor no read bit");
      wr_cfg(4, 8'h98);
      check(32'h604, 1, 3, 1'b0, "R9 locked denies machine");
      check(32'h608, 1, 3, 1'b1, "R6 8-byte edge then R10");
      wr_cfg(4, 8'h99);
      check(32'h600, 1, 3, 1'b1, "R9 locked read allowed");
      check(32'h600, 2, 3, 1'b0, "R9 locked store denied");

      // R3: selects 6 and 7 name no entry
      wr_cfg(6, 8'h1F);
      wr_adr(6, 30'h300);
      wr_cfg(7, 8'h1F);
      wr_adr(7, 30'h300);
      check(32'hC00, 1, 0, 1'b0, "R3 stray writes ignored");
      check(32'h500, 2, 1, 1'b1, "R3 existing entries untouched");

      // R2 / R12: write visible only after the edge
      wr_adr(5, 30'h380);
      @(negedge clk);
      chk_addr = 32'hE00; chk_type = 2'd1; chk_priv = 2'd0;
      cfg_we = 1'b1; cfg_sel = 3'd5; cfg_wdata = 8'h11;
      #1;
      expect_now(1'b0, "R2 old contents before edge");
      @(posedge clk);
      #1;
      expect_now(1'b1, "R2 R12 new contents after edge");
      @(negedge clk);
      cfg_we = 1'b0;
      sh_cfg[5] = 8'h11;

      // R6: all-ones power-of-two entry covers every address
      wr_adr(5, {ARW{1'b1}});
      wr_cfg(5, 8'h19);
      check(32'hFFFF_FFF0, 1, 0, 1'b1, "R6 full-space region");
      check(32'h8000_0000, 2, 0, 1'b0, "R6 full-space no write bit");

      // constrained random, packed into the first kilobyte
      for (int round = 0; round < 40; round++) begin
         for (int i = 0; i < NE; i++) begin
            int m, k;
            logic [ARW-1:0] av;
            logic [7:0] cv;
            m  = int'($urandom % 4);
            av = ARW'($urandom % 256);
            if (m == 3) begin
               k  = int'($urandom % 6);
               av = (av & ~ARW'((1 << (k + 1)) - 1)) | ARW'((1 << k) - 1);
            end
            cv = {($urandom % 4 == 0) ? 1'b1 : 1'b0, 2'b00, m[1:0], 3'($urandom)};
            wr_adr(i, av);
            wr_cfg(i, cv);
         end
         for (int n = 0; n < 50; n++) begin
            int t, p;
            logic [31:0] a;
            a = $urandom % 1100;
            t = int'($urandom % 3);
            p = int'($urandom % 3);
            if (p == 2) p = 3;
            check(a, t, p, ref_allow(a, t, p), "R7 R8 random");
         end
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule